// File: doc/BRIEF.md
# Interrupt Status-Word Swap Controller

This block performs the context switch for a simple processor when an interrupt is accepted. It holds the current status word, which carries the instruction address, one enable bit per interrupt class, a condition code and a problem/supervisor state bit. For each of six interrupt classes it keeps two slots: a saved word and a handler word. Accepting an interrupt writes the current word into that class's saved slot and makes the class's handler word current, so fetch resumes at the handler address. A return strobe names a class and makes that class's saved word current again.

There is no stack. Each class has exactly one saved slot, so nesting is controlled only by the class enable bits. The block adds a hardware rule on top of the handler word: entering an external or I/O handler disables both of those classes, and entering a machine-check handler disables machine checks. If a class is accepted again before its handler has returned, the first saved word is overwritten. The block does not prevent this. It reports it with a one-cycle flag.

Status word layout: bits 23:0 hold the instruction address. Bits 29:24 hold one bit per class, at bit 24 plus the class code. Bits 31:30 hold the condition code. Class codes are: external 0, supervisor call 1, program 2, machine check 3, I/O 4, restart 5. The bits for supervisor call and program carry no enable meaning. Bit 29, the restart position, is used as the problem-state bit and is carried through swaps unchanged.

Top module: `psw_swap_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the current word to zero, clears every saved slot, every handler slot and every in-service mark, and drives `intTaken`, `intClass` and `lostLink` to zero.
- R2: When an interrupt of class c is accepted at a clock edge, the following all happen at that same edge: the previous current word is written into saved slot c, handler slot c (after the R6 clearing) becomes the current word, `intTaken` is 1 for one cycle, and `intClass` equals c. `intClass` is 0 whenever `intTaken` is 0.
- R3: A return with class code r below 6 makes saved slot r the current word at the next edge. A return with code 6 or 7 changes nothing.
- R4: An external, I/O or machine-check request is accepted only while its enable bit (bit 24, 28 or 27 of the current word) is 1. Supervisor call, program and restart requests are accepted whatever the enable bits hold.
- R5: When several acceptable requests are present in one cycle, the winner is chosen in this order: restart, then machine check, then program, then supervisor call, then external, then I/O.
- R6: When an external or I/O interrupt is accepted, bits 24 and 28 are cleared in the word that becomes current. When a machine check is accepted, bit 27 is cleared in that word. All other bits come from the handler slot unchanged.
- R7: A valid return and a request in the same cycle complete the return only. Requests that are still present are evaluated in the next cycle against the restored word.
- R8: Accepting class c while class c is marked in service raises `lostLink` for that cycle and overwrites saved slot c, so a later return to c yields the second saved word. Accepting class c sets its mark, and a return to c clears it.
- R9: When `newWe` is 1 and `newSel` is below 6, handler slot `newSel` is written at the edge. Codes 6 and 7 write nothing. An interrupt accepted in the same cycle as a write to its own slot uses the slot's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | 6 | Request level per class; bit index equals class code |
| retStrobe | input | 1 | Return request |
| retClass | input | 3 | Class whose saved word is restored |
| newWe | input | 1 | Handler slot write enable |
| newSel | input | 3 | Handler slot index to write |
| newData | input | 32 | Handler word to write |
| curWord | output | 32 | Current status word |
| intTaken | output | 1 | One-cycle pulse: an interrupt was accepted at the last edge |
| intClass | output | 3 | Class accepted at the last edge |
| lostLink | output | 1 | The accepted class was already in service; its saved word was overwritten |

## Verification
The assertions assume that inputs are stable around the rising edge and that reset is asserted from time zero. The return-precedence property also assumes that a valid return never coincides with reset release. The stimulus drives every input at the falling edge and keeps reset high for several cycles before any request, return or slot write is applied. The random phase is free to hold requests for several cycles, to request a class that is already in service, and to use out-of-range class codes. The reference model covers all of these cases.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int ADDR_W  = 24;
  localparam int N_CLS   = 6;
  localparam int CC_W    = 2;
  localparam int WORD_W  = ADDR_W + N_CLS + CC_W;
  localparam int CLS_W   = $clog2(N_CLS);
  localparam int MASK_LO = ADDR_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_EXT = 3'd0,
    CLS_SVC = 3'd1,
    CLS_PRG = 3'd2,
    CLS_MCK = 3'd3,
    CLS_IO  = 3'd4,
    CLS_RST = 3'd5
  } cls_e;

  // classes that ignore their enable bit
  localparam logic [N_CLS-1:0] ALWAYS_ON = (N_CLS'(1) << CLS_SVC) |
                                           (N_CLS'(1) << CLS_PRG) |
                                           (N_CLS'(1) << CLS_RST);

  // lowest priority first; a later entry overrides an earlier one
  localparam logic [CLS_W*N_CLS-1:0] PRIO_LIST = {CLS_RST, CLS_MCK, CLS_PRG,
                                                  CLS_SVC, CLS_EXT, CLS_IO};

  typedef struct packed {
    logic             take;
    logic [CLS_W-1:0] takeCls;
    logic             ret;
    logic [CLS_W-1:0] retCls;
    logic [N_CLS-1:0] maskClr;
  } swap_strobe_t;
endpackage

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CLS-1:0] reqIn,
  input  logic             retStrobe,
  input  logic [CLS_W-1:0] retClass,
  input  logic [N_CLS-1:0] curMask,
  output swap_strobe_t     strobe,
  output logic             intTaken,
  output logic [CLS_W-1:0] intClass,
  output logic             lostLink
);
  logic [N_CLS-1:0] inService;
  logic [N_CLS-1:0] eligible;
  logic             retOk;
  logic             anyReq;
  logic [CLS_W-1:0] pick;

  always_comb begin
    retOk    = retStrobe && (retClass < CLS_W'(N_CLS));
    eligible = reqIn & (ALWAYS_ON | curMask);
    anyReq   = 1'b0;
    pick     = '0;
    for (int k = 0; k < N_CLS; k++) begin
      if (eligible[PRIO_LIST[k*CLS_W +: CLS_W]]) begin
        anyReq = 1'b1;
        pick   = PRIO_LIST[k*CLS_W +: CLS_W];
      end
    end
  end

  always_comb begin
    strobe.take    = anyReq && !retOk;
    strobe.takeCls = pick;
    strobe.ret     = retOk;
    strobe.retCls  = retClass;
    strobe.maskClr = '0;
    case (cls_e'(pick))
      CLS_EXT, CLS_IO: begin
        strobe.maskClr[CLS_EXT] = 1'b1;
        strobe.maskClr[CLS_IO]  = 1'b1;
      end
      CLS_MCK: strobe.maskClr[CLS_MCK] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inService <= '0;
      intTaken  <= 1'b0;
      intClass  <= '0;
      lostLink  <= 1'b0;
    end else begin
      intTaken <= strobe.take;
      intClass <= strobe.take ? pick : '0;
      lostLink <= strobe.take && inService[pick];
      if (retOk)
        inService[retClass] <= 1'b0;
      else if (strobe.take)
        inService[pick] <= 1'b1;
    end
  end
endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  swap_strobe_t      strobe,
  input  logic              newWe,
  input  logic [CLS_W-1:0]  newSel,
  input  logic [WORD_W-1:0] newData,
  output logic [WORD_W-1:0] curWord,
  output logic [N_CLS-1:0]  curMask
);
  logic [WORD_W-1:0] oldAll [N_CLS];
  logic [WORD_W-1:0] newAll [N_CLS];
  logic [WORD_W-1:0] loadWord;

  for (genvar g = 0; g < N_CLS; g++) begin : gSlot
    logic [WORD_W-1:0] oldQ;
    logic [WORD_W-1:0] newQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        oldQ <= '0;
        newQ <= '0;
      end else begin
        if (strobe.take && !strobe.ret && strobe.takeCls == CLS_W'(g))
          oldQ <= curWord;
        if (newWe && newSel == CLS_W'(g))
          newQ <= newData;
      end
    end
    assign oldAll[g] = oldQ;
    assign newAll[g] = newQ;
  end

  always_comb begin
    loadWord = newAll[strobe.takeCls];
    loadWord[MASK_LO +: N_CLS] = loadWord[MASK_LO +: N_CLS] & ~strobe.maskClr;
  end

  always_ff @(posedge clk) begin
    if (rst)
      curWord <= RESET_WORD;
    else if (strobe.ret)
      curWord <= oldAll[strobe.retCls];
    else if (strobe.take)
      curWord <= loadWord;
  end

  assign curMask = curWord[MASK_LO +: N_CLS];
endmodule

// File: rtl/psw_swap_ctrl.sv
module psw_swap_ctrl
  import psw_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CLS-1:0]  reqIn,
  input  logic              retStrobe,
  input  logic [CLS_W-1:0]  retClass,
  input  logic              newWe,
  input  logic [CLS_W-1:0]  newSel,
  input  logic [WORD_W-1:0] newData,
  output logic [WORD_W-1:0] curWord,
  output logic              intTaken,
  output logic [CLS_W-1:0]  intClass,
  output logic              lostLink
);
  swap_strobe_t     strobe;
  logic [N_CLS-1:0] curMask;

  psw_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqIn(reqIn), .retStrobe(retStrobe),
    .retClass(retClass), .curMask(curMask), .strobe(strobe),
    .intTaken(intTaken), .intClass(intClass), .lostLink(lostLink)
  );

  psw_datapath #(.RESET_WORD(RESET_WORD)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .newWe(newWe),
    .newSel(newSel), .newData(newData), .curWord(curWord), .curMask(curMask)
  );
endmodule

// File: rtl/psw_swap_chk.sv
module psw_swap_chk
  import psw_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [N_CLS-1:0]  reqIn,
  input logic              retStrobe,
  input logic [CLS_W-1:0]  retClass,
  input logic [WORD_W-1:0] curWord,
  input logic              intTaken,
  input logic [CLS_W-1:0]  intClass,
  input logic              lostLink
);
  a_r2_class_range: assert property (@(posedge clk) disable iff (rst)
    intTaken |-> intClass < CLS_W'(N_CLS));

  a_r4_ext_masked: assert property (@(posedge clk) disable iff (rst)
    !curWord[MASK_LO + CLS_EXT] |=> !(intTaken && intClass == CLS_EXT));

  a_r4_io_masked: assert property (@(posedge clk) disable iff (rst)
    !curWord[MASK_LO + CLS_IO] |=> !(intTaken && intClass == CLS_IO));

  a_r4_mck_masked: assert property (@(posedge clk) disable iff (rst)
    !curWord[MASK_LO + CLS_MCK] |=> !(intTaken && intClass == CLS_MCK));

  a_r5_restart_wins: assert property (@(posedge clk) disable iff (rst)
    (reqIn[CLS_RST] && !(retStrobe && retClass < CLS_W'(N_CLS)))
      |=> (intTaken && intClass == CLS_RST));

  a_r6_extio_closed: assert property (@(posedge clk) disable iff (rst)
    (intTaken && (intClass == CLS_EXT || intClass == CLS_IO))
      |-> (!curWord[MASK_LO + CLS_EXT] && !curWord[MASK_LO + CLS_IO]));

  a_r6_mck_closed: assert property (@(posedge clk) disable iff (rst)
    (intTaken && intClass == CLS_MCK) |-> !curWord[MASK_LO + CLS_MCK]);

  a_r7_return_first: assert property (@(posedge clk) disable iff (rst)
    (retStrobe && retClass < CLS_W'(N_CLS)) |=> !intTaken);

  a_r8_lost_needs_take: assert property (@(posedge clk) disable iff (rst)
    lostLink |-> intTaken);
endmodule

bind psw_swap_ctrl psw_swap_chk i_chk (
  .clk(clk), .rst(rst), .reqIn(reqIn), .retStrobe(retStrobe),
  .retClass(retClass), .curWord(curWord), .intTaken(intTaken),
  .intClass(intClass), .lostLink(lostLink)
);

// File: tb/test_psw_swap_ctrl.sv
`timescale 1ns/1ps
module test_psw_swap_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  reqIn = '0;
  logic        retStrobe = 1'b0;
  logic [2:0]  retClass = '0;
  logic        newWe = 1'b0;
  logic [2:0]  newSel = '0;
  logic [31:0] newData = '0;
  logic [31:0] curWord;
  logic        intTaken;
  logic [2:0]  intClass;
  logic        lostLink;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  logic [31:0] mCur;
  logic [31:0] mOld [6];
  logic [31:0] mNew [6];
  bit          mBusy [6];
  bit          mTaken, mLost;
  int          mCls;

  always #2 clk = ~clk;

  psw_swap_ctrl i_psw_swap_ctrl (
    .clk(clk), .rst(rst), .reqIn(reqIn), .retStrobe(retStrobe),
    .retClass(retClass), .newWe(newWe), .newSel(newSel), .newData(newData),
    .curWord(curWord), .intTaken(intTaken), .intClass(intClass),
    .lostLink(lostLink)
  );

  task automatic check(input bit ok, input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  function automatic bit enabledFor(int c);
    return (c == 1 || c == 2 || c == 5) || mCur[24 + c];
  endfunction

  task automatic modelStep();
    int order [6] = '{5, 3, 2, 1, 0, 4};
    logic [31:0] w;
    int best;
    mTaken = 0; mLost = 0; mCls = 0;
    if (rst) begin
      mCur = '0;
      for (int i = 0; i < 6; i++) begin mOld[i] = '0; mNew[i] = '0; mBusy[i] = 0; end
      return;
    end
    if (retStrobe && retClass < 6) begin
      mCur = mOld[retClass];
      mBusy[retClass] = 0;
    end else begin
      best = -1;
      foreach (order[i]) if (best < 0 && reqIn[order[i]] && enabledFor(order[i])) best = order[i];
      if (best >= 0) begin
        mTaken = 1; mCls = best; mLost = mBusy[best];
        mBusy[best] = 1;
        mOld[best] = mCur;
        w = mNew[best];
        if (best == 0 || best == 4) begin w[24] = 0; w[28] = 0; end
        if (best == 3) w[27] = 0;
        mCur = w;
      end
    end
    if (newWe && newSel < 6) mNew[newSel] = newData;
  endtask

  task automatic cyc();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check(curWord === mCur, tag, "curWord", curWord, mCur);
    check(intTaken === mTaken, tag, "intTaken", 32'(intTaken), 32'(mTaken));
    check(intClass === 3'(mCls), tag, "intClass", 32'(intClass), 32'(mCls));
    check(lostLink === mLost, tag, "lostLink", 32'(lostLink), 32'(mLost));
    reqIn = '0; retStrobe = 0; retClass = '0; newWe = 0; newSel = '0; newData = '0;
  endtask

  task automatic loadNew(input int s, input logic [31:0] d);
    newWe = 1; newSel = 3'(s); newData = d; cyc();
  endtask

  initial begin
    tag = "R1";
    repeat (3) cyc();
    rst = 0;
    check(curWord == 0 && !intTaken && !lostLink && intClass == 0, "R1",
          "reset outputs", curWord, 32'h0);

    tag = "R9";
    loadNew(0, 32'hFF000100);
    loadNew(1, 32'h3F000200);
    loadNew(2, 32'h3F000300);
    loadNew(3, 32'h3F000400);
    loadNew(4, 32'h3F000500);
    loadNew(5, 32'h3F000600);
    loadNew(6, 32'h12345678);

    tag = "R4"; reqIn = 6'b000001; cyc();
    check(!intTaken && curWord == 0, "R4", "ext masked", curWord, 32'h0);

    tag = "R2"; reqIn = 6'b000010; cyc();
    check(intTaken && intClass == 1 && curWord == 32'h3F000200, "R2",
          "svc swap", curWord, 32'h3F000200);

    tag = "R6"; reqIn = 6'b000001; cyc();
    check(curWord == 32'hEE000100, "R6", "ext clears ext/io", curWord, 32'hEE000100);

    tag = "R4"; reqIn = 6'b010000; cyc();
    check(!intTaken, "R4", "io masked in ext handler", 32'(intTaken), 32'h0);

    tag = "R7"; reqIn = 6'b010000; retStrobe = 1; retClass = 0; cyc();
    check(!intTaken && curWord == 32'h3F000200, "R7", "return first", curWord, 32'h3F000200);
    reqIn = 6'b010000; cyc();
    check(intTaken && intClass == 4 && curWord == 32'h2E000500, "R7",
          "io next cycle", curWord, 32'h2E000500);

    tag = "R3"; retStrobe = 1; retClass = 4; cyc();
    check(curWord == 32'h3F000200, "R3", "return io", curWord, 32'h3F000200);

    tag = "R5"; reqIn = 6'b111111; cyc();
    check(intClass == 5 && curWord == 32'h3F000600, "R5", "restart first", 32'(intClass), 32'd5);
    reqIn = 6'b011111; cyc();
    check(intClass == 3 && curWord == 32'h37000400, "R5", "mchk next", curWord, 32'h37000400);
    reqIn = 6'b000110; cyc();
    check(intClass == 2, "R5", "program over svc", 32'(intClass), 32'd2);
    tag = "R8"; reqIn = 6'b010011; cyc();
    check(intClass == 1 && lostLink, "R8", "svc retaken flags loss", 32'(lostLink), 32'h1);
    tag = "R5"; reqIn = 6'b010001; cyc();
    check(intClass == 0, "R5", "ext over io", 32'(intClass), 32'd0);

    tag = "R8"; retStrobe = 1; retClass = 1; cyc();
    check(curWord == 32'h3F000300, "R8", "overwritten link", curWord, 32'h3F000300);

    tag = "R3"; retStrobe = 1; retClass = 7; cyc();
    check(curWord == 32'h3F000300, "R3", "bad return ignored", curWord, 32'h3F000300);

    tag = "R9"; newWe = 1; newSel = 1; newData = 32'h3F000A00; reqIn = 6'b000010; cyc();
    check(curWord == 32'h3F000200, "R9", "same-cycle write uses old", curWord, 32'h3F000200);
    retStrobe = 1; retClass = 1; cyc();
    reqIn = 6'b000010; cyc();
    check(curWord == 32'h3F000A00, "R9", "new contents used", curWord, 32'h3F000A00);

    tag = "R2";
    for (int n = 0; n < 4000; n++) begin
      reqIn = 6'($urandom) & 6'($urandom) & 6'($urandom);
      if ($urandom_range(0, 5) == 0) begin retStrobe = 1; retClass = 3'($urandom); end
      if ($urandom_range(0, 7) == 0) begin newWe = 1; newSel = 3'($urandom); newData = $urandom; end
      cyc();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule